// File: doc/BRIEF.md
# Serial Word Deserializer with Control Voting

This block receives a serial bit stream at one bit per bit clock and turns it into parallel words. Each word is twenty bits, least significant bit first. A boundary strobe comes with the last bit of every word, and a phase flag sampled with that strobe says whether the word carries pixel data or control data. Pixel words put eighteen symbol bits on the pixel bus and raise data-enable. Control words put nine control bits on the control bus and lower data-enable. Five of the control bits are sent as three copies each, and the block recovers each one by a two-of-three majority vote, so a single flipped copy in a triple is corrected. The other four control bits are single copies and are taken as they are.

A small framing state machine decides when a word boundary is valid. It has four states. ST_FILL holds until twenty bits have arrived since reset. ST_RUN is normal collection. ST_LOAD_PIX and ST_LOAD_CTL each last one cycle and load the matching output register. A strobe seen in ST_FILL or ST_RUN with a full window moves the machine to ST_LOAD_PIX when the phase flag is 1, or to ST_LOAD_CTL when it is 0. Without a strobe the machine goes to ST_RUN once the window is full and stays in ST_FILL before that. A load state returns to ST_RUN, or goes straight to another load state if a new valid strobe arrives.

An output-enable input gates the three parallel outputs. The outputs are driven to zero by default, or to high impedance when the tristate variant is selected. Decoding carries on while the outputs are gated.

Top module: `serial_word_deser`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the first cycle after it, the pixel output, the control output and data-enable are all zero (output enable high).
- R2: Serial bits fill word positions in arrival order, with the first bit at position 0. A pixel word's positions 2 to 19 appear as pixel output bits 0 to 17. Positions 0 and 1 have no effect on any output.
- R3: A pixel-phase word (phase flag 1 at the strobe) drives data-enable to 1 and updates the pixel output, and the control output keeps its previous value.
- R4: A control-phase word (phase flag 0) drives data-enable to 0 and leaves the pixel output unchanged. Control bit k for k = 0..4 is the majority of word positions 1+3k, 2+3k and 3+3k. Control bits 5..8 equal word positions 16..19. Position 0 has no effect.
- R5: A single flipped copy within any voted triple is corrected. Two flipped copies change the recovered bit.
- R6: The outputs change only on the second rising edge counting the edge that samples an accepted strobe, and they hold their values on every other edge.
- R7: A strobe arriving before twenty bits have been received since reset is ignored and no output changes.
- R8: With output enable low, the pixel output, the control output and data-enable read zero. Words received in that time still update the internal registers, so raising output enable shows the most recent decoded values.
- R9: The decoded word is always the last twenty bits received up to and including the strobe bit. Extra bits between words and strobes spaced closer than twenty bits are both handled this way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ser_i | input | 1 | Serial data bit |
| strb_i | input | 1 | Word boundary strobe, high with the last bit of a word |
| phase_i | input | 1 | Word phase, 1 for pixel and 0 for control, sampled with the strobe |
| oe_i | input | 1 | Output enable for the parallel outputs |
| pix_o | output | 18 | Pixel symbol bus |
| ctl_o | output | 9 | Recovered control bus |
| de_o | output | 1 | Data-enable, high after a pixel word |

## Verification
The assertions assume that the phase flag is settled whenever the strobe is high. They also assume that reset is held for at least one full clock before any property depends on the registers it clears. They do not assume that strobes come every twenty bits.

The stimulus changes inputs one time unit after each rising edge, so the phase flag and the strobe are always stable at the sampling edge. Reset is held for three cycles. Strobe spacing is varied on purpose: an early strobe before the window fills, idle bits between words, and a strobe only five bits after the previous one.

// File: rtl/sdes_pkg.sv
package sdes_pkg;

    // Word layout; these positions are fixed by the line format.
    localparam int WORD_W     = 20;
    localparam int PIX_W      = 18;
    localparam int PIX_LSB    = 2;
    localparam int CTL_W      = 9;
    localparam int N_VOTED    = 5;
    localparam int N_COPY     = 3;
    localparam int VOTE_LSB   = 1;
    localparam int SINGLE_LSB = VOTE_LSB + N_VOTED * N_COPY;
    localparam int N_SINGLE   = CTL_W - N_VOTED;
    localparam int CNT_W      = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ST_FILL     = 2'd0,
        ST_RUN      = 2'd1,
        ST_LOAD_PIX = 2'd2,
        ST_LOAD_CTL = 2'd3
    } frm_state_e;

endpackage

// File: rtl/sdes_shifter.sv
module sdes_shifter
    import sdes_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ser_i,
    output logic [WORD_W-1:0] word_nxt_o,
    output logic              full_o
);

    logic [WORD_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    // Newest bit enters at the top, so the first bit ends at position 0.
    assign word_nxt_o = {ser_i, sh_q[WORD_W-1:1]};
    assign full_o     = (cnt_q == CNT_LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else begin
            sh_q <= word_nxt_o;
            if (cnt_q != CNT_LAST) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdes_framer.sv
module sdes_framer
    import sdes_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              strb_i,
    input  logic              phase_i,
    input  logic              full_i,
    input  logic [WORD_W-1:0] word_i,
    output frm_state_e        state_o,
    output logic              accept_o,
    output logic [WORD_W-1:0] word_o
);

    frm_state_e        state_q, state_d;
    logic [WORD_W-1:0] cap_q;

    assign accept_o = strb_i && full_i;
    assign state_o  = state_q;
    assign word_o   = cap_q;

    // State register.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if (accept_o) begin
                    state_d = phase_i ? ST_LOAD_PIX : ST_LOAD_CTL;
                end else if (full_i) begin
                    state_d = ST_RUN;
                end else begin
                    state_d = ST_FILL;
                end
            end
            ST_RUN, ST_LOAD_PIX, ST_LOAD_CTL: begin
                if (accept_o) begin
                    state_d = phase_i ? ST_LOAD_PIX : ST_LOAD_CTL;
                end else begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_FILL;
        endcase
    end

    // Capture the complete word at the accepted boundary.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cap_q <= '0;
        end else if (accept_o) begin
            cap_q <= word_i;
        end
    end

endmodule

// File: rtl/sdes_decode.sv
module sdes_decode
    import sdes_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic [PIX_W-1:0]  pix_o,
    output logic [CTL_W-1:0]  ctl_o
);

    assign pix_o = word_i[PIX_LSB +: PIX_W];

    for (genvar g = 0; g < N_VOTED; g++) begin : g_vote
        logic [N_COPY-1:0] trip;
        assign trip     = word_i[VOTE_LSB + g*N_COPY +: N_COPY];
        assign ctl_o[g] = (trip[0] & trip[1]) | (trip[0] & trip[2]) | (trip[1] & trip[2]);
    end

    for (genvar k = 0; k < N_SINGLE; k++) begin : g_single
        assign ctl_o[N_VOTED + k] = word_i[SINGLE_LSB + k];
    end

endmodule

// File: rtl/sdes_outreg.sv
module sdes_outreg
    import sdes_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  frm_state_e       state_i,
    input  logic [PIX_W-1:0] pix_i,
    input  logic [CTL_W-1:0] ctl_i,
    output logic [PIX_W-1:0] pix_q_o,
    output logic [CTL_W-1:0] ctl_q_o,
    output logic             de_q_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pix_q_o <= '0;
            ctl_q_o <= '0;
            de_q_o  <= 1'b0;
        end else begin
            unique case (state_i)
                ST_LOAD_PIX: begin
                    pix_q_o <= pix_i;
                    de_q_o  <= 1'b1;
                end
                ST_LOAD_CTL: begin
                    ctl_q_o <= ctl_i;
                    de_q_o  <= 1'b0;
                end
                ST_FILL, ST_RUN: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/serial_word_deser.sv
module serial_word_deser
    import sdes_pkg::*;
#(
    parameter bit OE_TRISTATE = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             ser_i,
    input  logic             strb_i,
    input  logic             phase_i,
    input  logic             oe_i,
    output logic [17:0]      pix_o,
    output logic [8:0]       ctl_o,
    output logic             de_o
);

    logic [WORD_W-1:0] word_nxt;
    logic              full;
    frm_state_e        frm_state;
    logic              accept;
    logic [WORD_W-1:0] cap_word;
    logic [PIX_W-1:0]  dec_pix;
    logic [CTL_W-1:0]  dec_ctl;
    logic [PIX_W-1:0]  pix_q;
    logic [CTL_W-1:0]  ctl_q;
    logic              de_q;

    sdes_shifter u_shift (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ser_i      (ser_i),
        .word_nxt_o (word_nxt),
        .full_o     (full)
    );

    sdes_framer u_frame (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .strb_i   (strb_i),
        .phase_i  (phase_i),
        .full_i   (full),
        .word_i   (word_nxt),
        .state_o  (frm_state),
        .accept_o (accept),
        .word_o   (cap_word)
    );

    sdes_decode u_dec (
        .word_i (cap_word),
        .pix_o  (dec_pix),
        .ctl_o  (dec_ctl)
    );

    sdes_outreg u_out (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .state_i (frm_state),
        .pix_i   (dec_pix),
        .ctl_i   (dec_ctl),
        .pix_q_o (pix_q),
        .ctl_q_o (ctl_q),
        .de_q_o  (de_q)
    );

    if (OE_TRISTATE) begin : g_oe_z
        assign pix_o = oe_i ? pix_q : 'z;
        assign ctl_o = oe_i ? ctl_q : 'z;
        assign de_o  = oe_i ? de_q  : 1'bz;
    end else begin : g_oe_zero
        assign pix_o = oe_i ? pix_q : '0;
        assign ctl_o = oe_i ? ctl_q : '0;
        assign de_o  = oe_i & de_q;
    end

endmodule

// File: rtl/sdes_checker.sv
module sdes_checker (
    input logic        clk_i,
    input logic        rst_i,
    input logic        strb_i,
    input logic        phase_i,
    input logic        oe_i,
    input logic        full_i,
    input logic        accept_i,
    input logic [17:0] pix_q_i,
    input logic [8:0]  ctl_q_i,
    input logic        de_q_i,
    input logic        de_o_i
);

    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (pix_q_i == '0 && ctl_q_i == '0 && !de_q_i));

    p_video_de_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (accept_i && phase_i) |=> ##1 de_q_i);

    p_video_ctl_held_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (accept_i && phase_i) |=> ##1 $stable(ctl_q_i));

    p_ctl_de_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (accept_i && !phase_i) |=> ##1 !de_q_i);

    p_ctl_pix_held_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (accept_i && !phase_i) |=> ##1 $stable(pix_q_i));

    p_idle_stable_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !accept_i |=> ##1 ($stable(pix_q_i) && $stable(ctl_q_i) && $stable(de_q_i)));

    p_early_strobe_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (strb_i && !full_i) |=> ##1 ($stable(pix_q_i) && $stable(ctl_q_i) && $stable(de_q_i)));

    p_oe_quiet_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !oe_i |-> (de_o_i !== 1'b1));

endmodule

bind serial_word_deser sdes_checker u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .strb_i   (strb_i),
    .phase_i  (phase_i),
    .oe_i     (oe_i),
    .full_i   (full),
    .accept_i (accept),
    .pix_q_i  (pix_q),
    .ctl_q_i  (ctl_q),
    .de_q_i   (de_q),
    .de_o_i   (de_o)
);

// File: tb/serial_word_deser_tb_top.sv
module serial_word_deser_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser = 1'b0;
    logic        strb = 1'b0;
    logic        phase = 1'b0;
    logic        oe = 1'b1;
    logic [17:0] pix;
    logic [8:0]  ctl;
    logic        de;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int nbits = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    logic   hist[$];
    int     due_q[$];
    bit     vid_q[$];
    logic [17:0] epix_q[$];
    logic [8:0]  ectl_q[$];
    string  tag_q[$];

    logic [17:0] m_pix = '0;
    logic [8:0]  m_ctl = '0;
    logic        m_de = 1'b0;

    serial_word_deser dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .ser_i   (ser),
        .strb_i  (strb),
        .phase_i (phase),
        .oe_i    (oe),
        .pix_o   (pix),
        .ctl_o   (ctl),
        .de_o    (de)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [27:0] act, input logic [27:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (de,ctl,pix)", tag, act, exp);
        end
    endtask

    function automatic logic maj3(input logic [2:0] t);
        return $countones(t) >= 2;
    endfunction

    // Drive one bit for one cycle; record expectation at an accepted strobe.
    task automatic send_bit(input logic b, input logic s, input logic ph, input string tag);
        logic [19:0] w;
        logic [8:0]  c;
        ser = b; strb = s; phase = ph;
        hist.push_back(b);
        if (hist.size() > 20) void'(hist.pop_front());
        nbits++;
        if (s && nbits >= 20) begin
            for (int i = 0; i < 20; i++) w[i] = hist[i];
            for (int k = 0; k < 5; k++) c[k] = maj3(w[1+3*k +: 3]);
            for (int k = 0; k < 4; k++) c[5+k] = w[16+k];
            due_q.push_back(cyc + 2);
            vid_q.push_back(ph);
            epix_q.push_back(w[19:2]);
            ectl_q.push_back(c);
            tag_q.push_back(tag);
        end
        @(posedge clk); #1;
    endtask

    task automatic send_word(input logic [19:0] w, input logic ph, input string tag);
        for (int i = 0; i < 20; i++) send_bit(w[i], (i == 19), ph, tag);
    endtask

    task automatic idle(input int n, input logic [31:0] pat);
        for (int i = 0; i < n; i++) send_bit(pat[i % 32], 1'b0, 1'b0, "idle");
    endtask

    function automatic logic [19:0] ctl_word(input logic [8:0] c, input logic [19:0] flips);
        logic [19:0] w;
        w[0] = 1'b1;
        for (int k = 0; k < 5; k++) w[1+3*k +: 3] = {3{c[k]}};
        for (int k = 0; k < 4; k++) w[16+k] = c[5+k];
        return w ^ flips;
    endfunction

    // Monitor: pop expectations at their due cycle and compare pins every cycle.
    always @(negedge clk) begin
        if (mon_en && !rst) begin
            string t;
            logic [27:0] e;
            t = "R6 hold";
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                void'(due_q.pop_front());
                if (vid_q.pop_front()) begin
                    m_pix = epix_q.pop_front(); void'(ectl_q.pop_front()); m_de = 1'b1;
                end else begin
                    void'(epix_q.pop_front()); m_ctl = ectl_q.pop_front(); m_de = 1'b0;
                end
                t = tag_q.pop_front();
            end
            e = oe ? {m_de, m_ctl, m_pix} : '0;
            check({de, ctl, pix} === e, t, {de, ctl, pix}, e);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check({de, ctl, pix} === 28'h0, "R1 in reset", {de, ctl, pix}, 28'h0);
        @(posedge clk); #1;
        rst = 1'b0;
        mon_en = 1'b1;
        nbits = 0;
        hist.delete();

        // R7: strobe after only twelve bits since reset must be ignored.
        for (int i = 0; i < 12; i++) send_bit(i[0], (i == 11), 1'b1, "R7");
        idle(3, 32'h5);
        check({de, ctl, pix} === 28'h0, "R7 early strobe", {de, ctl, pix}, 28'h0);

        // R2/R3: pixel words, EN bits varied; single-bit position probes.
        send_word({18'h2AB5C, 2'b01}, 1'b1, "R3 video");
        send_word({18'h00001, 2'b11}, 1'b1, "R2 bit2 to pix0");
        send_word({18'h20000, 2'b00}, 1'b1, "R2 bit19 to pix17");
        send_word({18'h00001, 2'b10}, 1'b1, "R2 EN ignored");

        // R4: control words, previous pixel held.
        send_word(ctl_word(9'h1A5, 20'h0), 1'b0, "R4 control");
        send_word(ctl_word(9'h05A, 20'h0), 1'b0, "R4 control");
        send_word({18'h15555, 2'b10}, 1'b1, "R3 video after ctl");

        // R5: one flipped copy per triple, then two flips in a triple.
        send_word(ctl_word(9'h0F3, 20'b0000_100_010_001_100_010_0), 1'b0, "R5 single error");
        send_word(ctl_word(9'h11F, 20'b0000_000_000_011_000_000_0), 1'b0, "R5 double error");
        send_word(ctl_word(9'h000, 20'b0000_101_000_000_000_110_0), 1'b0, "R5 double error");

        // R9: idle bits between words, then a strobe five bits after a word.
        idle(7, 32'h6B);
        send_word({18'h3C3C3, 2'b01}, 1'b1, "R9 after gap");
        for (int i = 0; i < 5; i++) send_bit(i[1], (i == 4), 1'b0, "R9 short spacing");
        send_word({18'h0F0F0, 2'b00}, 1'b1, "R9 realigned");

        // R8: output enable low; decoding continues underneath.
        oe = 1'b0;
        send_word({18'h1234A, 2'b00}, 1'b1, "R8 gated video");
        send_word(ctl_word(9'h0C7, 20'h0), 1'b0, "R8 gated control");
        idle(3, 32'h0);
        check({de, ctl, pix} === 28'h0, "R8 gated pins", {de, ctl, pix}, 28'h0);
        oe = 1'b1;
        @(negedge clk);
        check({de, ctl, pix} === {1'b0, 9'h0C7, 18'h1234A}, "R8 latest after enable",
              {de, ctl, pix}, {1'b0, 9'h0C7, 18'h1234A});
        @(posedge clk); #1;

        // R6: repeated identical word, then idle to confirm hold.
        send_word({18'h1234A, 2'b01}, 1'b1, "R6 repeat");
        idle(25, 32'hDEAD_BEEF);

        // R1: reset mid-stream clears outputs.
        rst = 1'b1;
        mon_en = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check({de, ctl, pix} === 28'h0, "R1 after reset", {de, ctl, pix}, 28'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule